// File: doc/BRIEF.md
# Paged EEPROM Write and Address Core

This block is the memory side of a 2048-byte serial EEPROM model. A protocol front-end, which is not part of this block, decodes bus traffic into single-cycle events: load a word address, deliver a data byte, request a read byte, or signal a stop. The core keeps one address counter for both reads and writes. Incoming data bytes go into a 16-byte page buffer, and the buffer is written into a synthesizable byte array only after a stop, during a self-timed write cycle. The busy flag is high for that whole cycle. A write-protect input can shield the upper half of the array.

The address counter behaves differently for writes and reads. After a data byte, only the low four bits of the counter advance, so a burst stays inside one 16-byte page and wraps back to the start of that page. After a read, the full 11-bit counter advances, and it wraps from the last byte of the array to byte 0. Between operations the counter keeps its value, which is the last accessed address plus one. A read with no new address load uses that value as the current address.

The control sequencer has four states:
- `ST_IDLE`: no data is pending.
- `ST_FILL`: at least one data byte has been buffered since the last address load.
- `ST_COMMIT`: the buffered page is copied to the array, one slot per clock.
- `ST_HOLD`: the remaining write-cycle time runs out.

The transitions are:
- IDLE to FILL on a data byte.
- IDLE or FILL to COMMIT on a stop that follows or coincides with a data byte.
- FILL to IDLE on an address load, which discards the buffer.
- COMMIT to HOLD after the last page slot.
- COMMIT or HOLD to IDLE when the write-cycle timer reaches zero.

Top module: `eeprom_page_core`

## Requirements
- R1: An address load sets the counter to the 11-bit value. A read request outputs the byte at the counter with `rd_valid_o` high on the next clock, and then increments the counter.
- R2: Each data byte is stored at the counter's low 4 bits within the page selected by bits 10..4. Only those low 4 bits increment, wrapping from 15 to 0 in the same page.
- R3: If more than 16 bytes are sent in one sequence, the later bytes overwrite the earlier ones in the same page slots, and the last byte sent to a slot wins.
- R4: At commit, only the page slots that received a byte in the current sequence are written. All other bytes of the page keep their contents.
- R5: A stop writes the array only if a data byte arrived since the last address load. A stop after an address load alone leaves `busy_o` low, and the loaded address is kept as the current address.
- R6: `busy_o` rises on the clock edge that samples the qualifying stop and stays high for exactly WR_CYCLES clocks. This holds even if every buffered byte was protected.
- R7: While `busy_o` is high, address loads, data bytes, read requests and stops are ignored. No read data is returned for them.
- R8: With no new address load, a read starts at the last accessed address plus one, after either a write or a read.
- R9: Reads step across page boundaries and wrap from address 2047 to address 0.
- R10: While `wp_i` is high, data bytes aimed at addresses 1024..2047 are acknowledged and advance the counter, but the array is not changed for them. Addresses 0..1023 stay writable.
- R11: A data byte that arrives in the same cycle as a stop is included in the page that the stop commits.
- R12: After reset, `busy_o` and `rd_valid_o` are low and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | High blocks writes to the upper half of the array |
| addr_load_i | input | 1 | Word-address load event |
| addr_val_i | input | 11 | Word address carried with the load event |
| byte_wr_i | input | 1 | Data byte event |
| byte_val_i | input | 8 | Data byte value |
| rd_req_i | input | 1 | Read byte request event |
| stop_i | input | 1 | Stop event |
| busy_o | output | 1 | High during the internal write cycle |
| rd_valid_o | output | 1 | Read data valid, one clock after an accepted request |
| rd_data_o | output | 8 | Read data byte |

## Verification
The last data byte of a burst and the stop that ends the burst can land in the same cycle. Buffering that byte and starting the commit then happen on one clock edge. The bench provokes this by driving `byte_wr_i` and `stop_i` together after one ordinary byte. It then times `busy_o` to check that the write cycle ran exactly once and for the full length. Finally it reads back the slot that the coincident byte targeted, and the byte must be present in the array.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_HOLD   = 2'd3
    } eepc_state_t;
endpackage

// File: rtl/eepc_ctrl.sv
module eepc_ctrl
    import eepc_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_evt,
    input  logic              data_evt,
    input  logic              rd_evt,
    input  logic              stop_evt,
    output logic              take_addr,
    output logic              take_data,
    output logic              take_rd,
    output logic              busy,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx,
    output logic              buf_clear
);
    localparam int TW = $clog2(WR_CYCLES + 2);
    localparam logic [PAGE_W-1:0] SLOT_LAST = {PAGE_W{1'b1}};
    localparam logic [TW-1:0]     T_LOAD    = TW'(WR_CYCLES - 1);

    eepc_state_t       state_q, state_d;
    logic [TW-1:0]     timer_q;
    logic [PAGE_W-1:0] idx_q;
    logic              start_cycle;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (data_evt && stop_evt) state_d = ST_COMMIT;
                else if (data_evt)        state_d = ST_FILL;
            end
            ST_FILL: begin
                if (stop_evt)      state_d = ST_COMMIT;
                else if (addr_evt) state_d = ST_IDLE;
            end
            ST_COMMIT: begin
                if (timer_q == '0)          state_d = ST_IDLE;
                else if (idx_q == SLOT_LAST) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (timer_q == '0) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign start_cycle = (state_d == ST_COMMIT) &&
                         ((state_q == ST_IDLE) || (state_q == ST_FILL));

    // write-cycle timer and commit slot index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            idx_q   <= '0;
        end else if (start_cycle) begin
            timer_q <= T_LOAD;
            idx_q   <= '0;
        end else if (busy) begin
            if (timer_q != '0) timer_q <= timer_q - 1'b1;
            if (state_q == ST_COMMIT) idx_q <= idx_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q == ST_COMMIT) || (state_q == ST_HOLD);
        take_addr  = addr_evt && !busy;
        take_data  = data_evt && !busy;
        take_rd    = rd_evt && !busy;
        commit_en  = (state_q == ST_COMMIT);
        commit_idx = idx_q;
        buf_clear  = take_addr || (busy && timer_q == '0);
    end

    logic [TW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == TW'(WR_CYCLES));

    // R6
    busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < TW'(WR_CYCLES));
endmodule

// File: rtl/eepc_addr_ctr.sv
module eepc_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step_page,
    input  logic              step_lin,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [ADDR_W-1:0] addr_q;
    logic [PAGE_W-1:0] slot_nx;

    assign slot_nx = addr_q[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (load)      addr_q <= load_addr;
        else if (step_page) addr_q <= {addr_q[ADDR_W-1:PAGE_W], slot_nx};
        else if (step_lin)  addr_q <= addr_q + 1'b1;
    end

    assign addr_o = addr_q;

    // R2
    page_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_page && !load) |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

    // R9
    lin_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_lin && !load && !step_page && addr_o == {ADDR_W{1'b1}}) |=> addr_o == '0);

    // R1
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> addr_o == $past(load_addr));

    localparam int ROW_CHK = ROW_W;
    initial begin
        row_width_chk: assert (ROW_CHK > 0);
    end
endmodule

// File: rtl/eepc_page_buf.sv
module eepc_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8,
    parameter int ROW_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_block,
    input  logic              clear,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ROW_W-1:0]  row_o
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [DATA_W-1:0] data_q [SLOTS];
    logic [SLOTS-1:0]  mask_q;
    logic [ROW_W-1:0]  row_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr && wr_idx == PAGE_W'(s)) data_q[s] <= wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n)                          mask_q[s] <= 1'b0;
            else if (clear)                      mask_q[s] <= 1'b0;
            else if (wr && wr_idx == PAGE_W'(s)) mask_q[s] <= !wr_block;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  row_q <= '0;
        else if (wr) row_q <= wr_row;
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = mask_q[rd_idx];
    assign row_o    = row_q;

    // R10
    blocked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_block && !clear) |=> !mask_q[$past(wr_idx)]);

    // R4
    clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> mask_q == '0);
endmodule

// File: rtl/eepc_array.sv
module eepc_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/eeprom_page_core.sv
module eeprom_page_core #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_val_i,
    input  logic              byte_wr_i,
    input  logic [DATA_W-1:0] byte_val_i,
    input  logic              rd_req_i,
    input  logic              stop_i,
    output logic              busy_o,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic              take_addr, take_data, take_rd, busy;
    logic              commit_en, buf_clear;
    logic [PAGE_W-1:0] commit_idx;
    logic [ADDR_W-1:0] addr_q;
    logic              blocked;
    logic [DATA_W-1:0] slot_data;
    logic              slot_valid;
    logic [ROW_W-1:0]  commit_row;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic              rd_valid_q;

    eepc_ctrl #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_evt   (addr_load_i),
        .data_evt   (byte_wr_i),
        .rd_evt     (rd_req_i),
        .stop_evt   (stop_i),
        .take_addr  (take_addr),
        .take_data  (take_data),
        .take_rd    (take_rd),
        .busy       (busy),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .buf_clear  (buf_clear)
    );

    eepc_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_addr),
        .load_addr (addr_val_i),
        .step_page (take_data),
        .step_lin  (take_rd),
        .addr_o    (addr_q)
    );

    // upper half of the array is selected by the top address bit
    assign blocked = wp_i && addr_q[ADDR_W-1];

    eepc_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .ROW_W(ROW_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (take_data),
        .wr_idx   (addr_q[PAGE_W-1:0]),
        .wr_row   (addr_q[ADDR_W-1:PAGE_W]),
        .wr_data  (byte_val_i),
        .wr_block (blocked),
        .clear    (buf_clear),
        .rd_idx   (commit_idx),
        .rd_data  (slot_data),
        .rd_valid (slot_valid),
        .row_o    (commit_row)
    );

    assign arr_we    = commit_en && slot_valid;
    assign arr_waddr = {commit_row, commit_idx};

    eepc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (slot_data),
        .re    (take_rd),
        .raddr (addr_q),
        .rdata (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid_q <= 1'b0;
        else        rd_valid_q <= take_rd;
    end

    assign busy_o     = busy;
    assign rd_valid_o = rd_valid_q;

    // R7
    arr_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy_o);

    // R1
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_req_i && !busy_o));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    // R7
    no_read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !rd_valid_o);
endmodule

// File: tb/eeprom_page_core_tb_top.sv
`timescale 1ns/1ps
module eeprom_page_core_tb_top;
    localparam int WR = 40;
    localparam int NV = 59;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp = 1'b0;
    logic        aload = 1'b0;
    logic [10:0] aval = '0;
    logic        bwr = 1'b0;
    logic [7:0]  bval = '0;
    logic        rreq = 1'b0;
    logic        stp = 1'b0;
    logic        busy, rvalid;
    logic [7:0]  rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    eeprom_page_core #(.WR_CYCLES(WR)) dut_i (
        .clk(clk), .rst_n(rst_n), .wp_i(wp),
        .addr_load_i(aload), .addr_val_i(aval),
        .byte_wr_i(bwr), .byte_val_i(bval),
        .rd_req_i(rreq), .stop_i(stp),
        .busy_o(busy), .rd_valid_o(rvalid), .rd_data_o(rdata)
    );

    // vector: tag[25:22] op[21:19] addr[18:8] byte[7:0]
    // op 0 address load, 1 data byte, 2 stop and time busy, 3 read and compare,
    // op 4 set protect, 5 stop expecting no busy
    localparam logic [25:0] VEC [NV] = '{
        {4'd0, 3'd0, 11'h010, 8'h00}, {4'd0, 3'd1, 11'h000, 8'hAA},
        {4'd0, 3'd1, 11'h000, 8'hBB}, {4'd6, 3'd2, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h010, 8'h00}, {4'd1, 3'd3, 11'h000, 8'hAA},  // R1
        {4'd0, 3'd0, 11'h030, 8'h00}, {4'd0, 3'd1, 11'h000, 8'h44},
        {4'd6, 3'd2, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h02E, 8'h00}, {4'd0, 3'd1, 11'h000, 8'h11},
        {4'd0, 3'd1, 11'h000, 8'h22}, {4'd0, 3'd1, 11'h000, 8'h33},  // R2 wraps to 0x020
        {4'd6, 3'd2, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h02F, 8'h00}, {4'd2, 3'd3, 11'h000, 8'h22},
        {4'd9, 3'd3, 11'h000, 8'h44},                                  // R9 crosses page
        {4'd0, 3'd0, 11'h020, 8'h00}, {4'd2, 3'd3, 11'h000, 8'h33},
        {4'd0, 3'd0, 11'h050, 8'h00}, {4'd0, 3'd1, 11'h000, 8'h55},
        {4'd0, 3'd1, 11'h000, 8'h66}, {4'd6, 3'd2, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h050, 8'h00}, {4'd0, 3'd1, 11'h000, 8'h77},
        {4'd6, 3'd2, 11'h000, 8'h00}, {4'd4, 3'd3, 11'h000, 8'h66},  // R4
        {4'd0, 3'd0, 11'h400, 8'h00}, {4'd0, 3'd1, 11'h000, 8'hC1},
        {4'd0, 3'd1, 11'h000, 8'hC2}, {4'd0, 3'd1, 11'h000, 8'hC3},
        {4'd6, 3'd2, 11'h000, 8'h00}, {4'd0, 3'd4, 11'h001, 8'h00},
        {4'd0, 3'd0, 11'h400, 8'h00}, {4'd0, 3'd1, 11'h000, 8'hD1},
        {4'd0, 3'd1, 11'h000, 8'hD2}, {4'd6, 3'd2, 11'h000, 8'h00},  // R6 all protected
        {4'd10, 3'd3, 11'h000, 8'hC3},                                 // R10
        {4'd0, 3'd0, 11'h3F0, 8'h00}, {4'd0, 3'd1, 11'h000, 8'hE3},
        {4'd6, 3'd2, 11'h000, 8'h00}, {4'd0, 3'd4, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h400, 8'h00}, {4'd10, 3'd3, 11'h000, 8'hC1},
        {4'd0, 3'd0, 11'h3F0, 8'h00}, {4'd10, 3'd3, 11'h000, 8'hE3},
        {4'd0, 3'd0, 11'h7FF, 8'h00}, {4'd0, 3'd1, 11'h000, 8'h5A},
        {4'd6, 3'd2, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h000, 8'h00}, {4'd0, 3'd1, 11'h000, 8'hA5},
        {4'd6, 3'd2, 11'h000, 8'h00},
        {4'd0, 3'd0, 11'h7FF, 8'h00}, {4'd9, 3'd3, 11'h000, 8'h5A},
        {4'd9, 3'd3, 11'h000, 8'hA5},                                  // R9 end wrap
        {4'd0, 3'd0, 11'h010, 8'h00}, {4'd5, 3'd5, 11'h000, 8'h00},  // R5
        {4'd5, 3'd3, 11'h000, 8'hAA}, {4'd8, 3'd3, 11'h000, 8'hBB}   // R8
    };

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            4'd12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ev_addr(input logic [10:0] a);
        @(negedge clk); aload = 1'b1; aval = a;
        @(negedge clk); aload = 1'b0;
    endtask

    task automatic ev_data(input logic [7:0] d);
        @(negedge clk); bwr = 1'b1; bval = d;
        @(negedge clk); bwr = 1'b0;
    endtask

    task automatic time_busy(input string tag);
        int cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == WR, tag, cnt, WR);
    endtask

    task automatic ev_stop_busy(input string tag);
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0;
        time_busy(tag);
    endtask

    task automatic ev_stop_idle(input string tag);
        bit seen = 1'b0;
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (busy) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, tag, seen, 0);
    endtask

    task automatic do_read(input logic [7:0] exp, input string tag);
        @(negedge clk); rreq = 1'b1;
        @(negedge clk); rreq = 1'b0;
        check(rvalid === 1'b1, tag, rvalid, 1);
        check(rdata === exp, tag, rdata, exp);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(busy === 1'b0, "R12", busy, 0);
        check(rvalid === 1'b0, "R12", rvalid, 0);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            case (v[21:19])
                3'd0: ev_addr(v[18:8]);
                3'd1: ev_data(v[7:0]);
                3'd2: ev_stop_busy(tname(v[25:22]));
                3'd3: do_read(v[7:0], tname(v[25:22]));
                3'd4: begin @(negedge clk); wp = v[8]; end
                3'd5: ev_stop_idle(tname(v[25:22]));
                default: ;
            endcase
        end

        // R3: 17 bytes into one page, the last lands on slot 0
        ev_addr(11'h100);
        for (int j = 0; j < 17; j++) ev_data(8'h80 + 8'(j));
        ev_stop_busy("R6");
        ev_addr(11'h100);
        do_read(8'h90, "R3");
        do_read(8'h81, "R3");

        // R7: commands during the write cycle are ignored
        ev_addr(11'h060);
        ev_data(8'h01);
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0;
        ev_addr(11'h060);
        ev_data(8'h99);
        @(negedge clk); rreq = 1'b1;
        @(negedge clk); rreq = 1'b0;
        check(rvalid === 1'b0, "R7", rvalid, 0);
        @(negedge clk); stp = 1'b1;
        @(negedge clk); stp = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(busy === 1'b0, "R7", busy, 0);
        ev_addr(11'h060);
        do_read(8'h01, "R7");

        // R11: data byte together with the stop
        ev_addr(11'h080);
        ev_data(8'h10);
        @(negedge clk); bwr = 1'b1; bval = 8'h20; stp = 1'b1;
        @(negedge clk); bwr = 1'b0; stp = 1'b0;
        time_busy("R11");
        ev_addr(11'h081);
        do_read(8'h20, "R11");
        ev_addr(11'h080);
        do_read(8'h10, "R11");

        finish_run();
    end
endmodule